// File: doc/BRIEF.md
# Auto-Detecting Serial Register Port

This block is a slave serial port that lets a host read and write a bank of 128 eight-bit registers. The host uses an active-low chip select, a serial clock and two data pins. The first data pin can be bidirectional and is modelled as a separate input, output and output enable. The second data pin only receives. Every transaction is two bytes long: a command byte that carries the direction and the register address, then one data byte.

The block does not need a mode pin. At each falling edge of chip select it looks at the serial clock level and chooses one of two host protocols for that transaction:

- **Clock high:** a single-line, LSB-first protocol. Both directions use the first data pin.
- **Clock low:** SPI mode 0, MSB first. Data is received on the second pin and sent on the first.

All pins are sampled into a 250 MHz core clock through a two-stage synchroniser. Every serial event is then handled as an edge detected on that clock.

The controller is a finite-state machine with seven states:

| State | Transition out |
|-------|----------------|
| IDLE | goes to CMD on a chip-select fall, and latches the mode at that moment |
| CMD | shifts in 8 command bits, then goes to FETCH for a read or WDATA for a write |
| FETCH | loads the addressed register into the transmit shifter, then goes to RDATA |
| RDATA | drives one bit per serial falling edge; after the 8th rising edge goes to HOLD |
| WDATA | shifts in 8 data bits, then goes to COMMIT |
| COMMIT | writes the register, then goes to HOLD |
| HOLD | waits for chip select to rise |

A rise of chip select in CMD, FETCH, RDATA, WDATA or HOLD returns the machine to IDLE.

Top module: `serreg_port`

## Requirements
- R1: At each falling edge of `cs_n`, the block latches the `sclk` level as the transaction mode: 1 selects the single-line LSB-first mode and 0 selects SPI mode 0. The mode is held until the next falling edge of `cs_n`.
- R2: In single-line mode, all bits are received on `dio_in` and `rx_in` is ignored. The command byte is sent as the R/W bit (1 = read) followed by address bits a0 through a6. The data byte is sent and returned LSB first.
- R3: In SPI mode, bits are received on `rx_in` and `dio_in` is ignored. The command byte is sent as the R/W bit followed by address bits a6 through a0. The data byte is sent and returned MSB first on `dio_out`.
- R4: Received bits are taken at rising edges of `sclk`. Transmitted bits change only after falling edges of `sclk`. The first read-data bit appears after the first falling edge that follows the 8th rising edge.
- R5: A write updates the register only after the 16th rising edge. A transaction ended early by `cs_n` rising leaves every register unchanged.
- R6: `dio_oe` is low once `cs_n` has been high for four core clocks, and it stays low while `cs_n` is high.
- R7: `dio_oe` is high while read data is being returned, and it stays low for the whole of a write transaction.
- R8: After reset, all registers read as zero, `dio_oe` is low and `dio_out` is low.
- R9: In SPI mode, activity on `rx_in` during the data byte of a read does not change any register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select from the host |
| sclk | input | 1 | Serial clock from the host |
| dio_in | input | 1 | Receive side of the first data pin |
| rx_in | input | 1 | Second data pin, receive only |
| dio_out | output | 1 | Transmit side of the first data pin |
| dio_oe | output | 1 | Output enable for the first data pin |

## Verification
The bench checks three kinds of failure, each seen at the ports within one transaction:

- **Wrong latched mode or bit order.** The next read-back returns the byte reversed or taken from the wrong address. Writing in one mode and reading in the other catches this.
- **Wrong counter or state.** The read data arrives one bit early or late, or a write commits when it should have been aborted. Both appear on the following read.
- **Stale output enable.** The first data pin is still driven four core clocks after `cs_n` rises, or is driven during a write.

// File: rtl/serreg_pkg.sv
package serreg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_FETCH,
        ST_RDATA,
        ST_WDATA,
        ST_COMMIT,
        ST_HOLD
    } srp_state_e;

    typedef enum logic {
        MODE_SPI = 1'b0,
        MODE_LSB = 1'b1
    } srp_mode_e;

endpackage

// File: rtl/serreg_sync.sv
module serreg_sync #(
    parameter int          W    = 4,
    parameter logic [W-1:0] INIT = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage1;

    // Two flops per bit: every pin sees the same latency, so data stays
    // aligned with the clock edges that are detected from it.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= INIT;
            q      <= INIT;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end

endmodule

// File: rtl/serreg_bank.sv
module serreg_bank #(
    parameter int AW = 7,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] rd_bus [DEPTH];

    // One register per entry, each with its own write decode.
    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        logic [DW-1:0] q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q <= '0;
            end else if (wr_en && (addr == AW'(g))) begin
                q <= wr_data;
            end
        end

        assign rd_bus[g] = q;
    end

    assign rd_data = rd_bus[addr];

endmodule

// File: rtl/serreg_ctrl.sv
module serreg_ctrl
    import serreg_pkg::*;
#(
    parameter int AW = 7,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_s,
    input  logic          sclk_s,
    input  logic          dio_s,
    input  logic          rx_s,
    input  logic [DW-1:0] rd_data,
    output logic [AW-1:0] addr,
    output logic          wr_en,
    output logic [DW-1:0] wr_data,
    output logic          dio_out,
    output logic          dio_oe,
    output srp_state_e    st,
    output srp_mode_e     mode,
    output logic          rd_flag,
    output logic          sclk_fall
);

    localparam int CW    = AW + 1;
    localparam int MAXW  = (CW > DW) ? CW : DW;
    localparam int CNT_W = $clog2(MAXW) + 1;

    srp_state_e       nxt;
    logic             cs_d;
    logic             sclk_d;
    logic             cs_fall;
    logic             sclk_rise;
    logic             lsb;
    logic             rx_bit;
    logic [CNT_W-1:0] cnt;
    logic [CW-1:0]    cmd_sr;
    logic [DW-1:0]    dat_sr;
    logic [DW-1:0]    tx_sr;

    // Edge detection on the synchronised pins.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_d   <= 1'b1;
            sclk_d <= 1'b0;
        end else begin
            cs_d   <= cs_s;
            sclk_d <= sclk_s;
        end
    end

    assign cs_fall   = cs_d & ~cs_s;
    assign sclk_rise = sclk_s & ~sclk_d;
    assign sclk_fall = ~sclk_s & sclk_d;
    assign lsb       = (mode == MODE_LSB);
    assign rx_bit    = lsb ? dio_s : rx_s;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= ST_IDLE;
        end else begin
            st <= nxt;
        end
    end

    // Next-state logic.
    always_comb begin
        nxt = st;
        unique case (st)
            ST_IDLE: begin
                if (cs_fall) begin
                    nxt = ST_CMD;
                end
            end
            ST_CMD: begin
                if (cs_s) begin
                    nxt = ST_IDLE;
                end else if (sclk_rise && (cnt == CNT_W'(CW - 1))) begin
                    nxt = rd_flag ? ST_FETCH : ST_WDATA;
                end
            end
            ST_FETCH: begin
                nxt = cs_s ? ST_IDLE : ST_RDATA;
            end
            ST_RDATA: begin
                if (cs_s) begin
                    nxt = ST_IDLE;
                end else if (sclk_rise && (cnt == CNT_W'(DW - 1))) begin
                    nxt = ST_HOLD;
                end
            end
            ST_WDATA: begin
                if (cs_s) begin
                    nxt = ST_IDLE;
                end else if (sclk_rise && (cnt == CNT_W'(DW - 1))) begin
                    nxt = ST_COMMIT;
                end
            end
            ST_COMMIT: begin
                // All 16 bits have arrived, so the write goes ahead even if
                // chip select has just risen.
                nxt = ST_HOLD;
            end
            ST_HOLD: begin
                if (cs_s) begin
                    nxt = ST_IDLE;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // Shifters, bit counter and latched mode.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            mode    <= MODE_SPI;
            rd_flag <= 1'b0;
            cmd_sr  <= '0;
            dat_sr  <= '0;
            tx_sr   <= '0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    cnt <= '0;
                    if (cs_fall) begin
                        mode <= sclk_s ? MODE_LSB : MODE_SPI;
                    end
                end
                ST_CMD: begin
                    if (sclk_rise) begin
                        // The direction bit comes first in both modes.
                        if (cnt == '0) begin
                            rd_flag <= rx_bit;
                        end
                        cmd_sr <= lsb ? {rx_bit, cmd_sr[CW-1:1]}
                                      : {cmd_sr[CW-2:0], rx_bit};
                        cnt    <= (cnt == CNT_W'(CW - 1)) ? '0
                                                          : cnt + CNT_W'(1);
                    end
                end
                ST_FETCH: begin
                    tx_sr <= rd_data;
                end
                ST_RDATA: begin
                    if (sclk_rise) begin
                        cnt <= cnt + CNT_W'(1);
                    end
                    if (sclk_fall) begin
                        tx_sr <= lsb ? {1'b0, tx_sr[DW-1:1]}
                                     : {tx_sr[DW-2:0], 1'b0};
                    end
                end
                ST_WDATA: begin
                    if (sclk_rise) begin
                        cnt    <= cnt + CNT_W'(1);
                        dat_sr <= lsb ? {rx_bit, dat_sr[DW-1:1]}
                                      : {dat_sr[DW-2:0], rx_bit};
                    end
                end
                default: ;
            endcase
        end
    end

    // Output register for the first data pin.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dio_out <= 1'b0;
            dio_oe  <= 1'b0;
        end else if (cs_s || (st == ST_IDLE)) begin
            dio_oe <= 1'b0;
        end else if ((st == ST_RDATA) && sclk_fall) begin
            dio_out <= lsb ? tx_sr[0] : tx_sr[DW-1];
            dio_oe  <= 1'b1;
        end
    end

    // Command decode: LSB-first mode receives a0 first, SPI mode a6 first.
    assign addr    = lsb ? cmd_sr[CW-1:1] : cmd_sr[AW-1:0];
    assign wr_en   = (st == ST_COMMIT);
    assign wr_data = dat_sr;

endmodule

// File: rtl/serreg_port.sv
module serreg_port
    import serreg_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk,
    input  logic dio_in,
    input  logic rx_in,
    output logic dio_out,
    output logic dio_oe
);

    logic [3:0]        pins_s;
    logic              cs_s;
    logic              sclk_s;
    logic              dio_s;
    logic              rx_s;
    logic [ADDR_W-1:0] addr;
    logic              wr_en;
    logic [DATA_W-1:0] wr_data;
    logic [DATA_W-1:0] rd_data;
    srp_state_e        st;
    srp_mode_e         mode;
    logic              rd_flag;
    logic              sclk_fall;

    serreg_sync #(
        .W    (4),
        .INIT (4'b1000)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cs_n, sclk, dio_in, rx_in}),
        .q     (pins_s)
    );

    assign cs_s   = pins_s[3];
    assign sclk_s = pins_s[2];
    assign dio_s  = pins_s[1];
    assign rx_s   = pins_s[0];

    serreg_ctrl #(
        .AW (ADDR_W),
        .DW (DATA_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_s      (cs_s),
        .sclk_s    (sclk_s),
        .dio_s     (dio_s),
        .rx_s      (rx_s),
        .rd_data   (rd_data),
        .addr      (addr),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .dio_out   (dio_out),
        .dio_oe    (dio_oe),
        .st        (st),
        .mode      (mode),
        .rd_flag   (rd_flag),
        .sclk_fall (sclk_fall)
    );

    serreg_bank #(
        .AW (ADDR_W),
        .DW (DATA_W)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (addr),
        .wr_data (wr_data),
        .rd_data (rd_data)
    );

endmodule

// File: rtl/serreg_port_chk.sv
module serreg_port_chk
    import serreg_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       dio_out,
    input logic       dio_oe,
    input logic       wr_en,
    input logic       rd_flag,
    input logic       sclk_fall,
    input srp_state_e st,
    input srp_mode_e  mode
);

    // R6: the pin is released once chip select has stayed high.
    p_oe_off_cs_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3) && $past(cs_n, 4)
        |-> !dio_oe);

    // R7: the pin is driven only for a read.
    p_oe_read_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dio_oe |-> rd_flag);

    // R5: a commit belongs to a write command.
    p_commit_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !rd_flag);

    // R5: one commit per transaction.
    p_commit_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    // R1: the mode does not change inside a transaction.
    p_mode_stable_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE) && ($past(st) != ST_IDLE) |-> $stable(mode));

    // R4: transmit data changes only after a serial clock falling edge.
    p_out_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dio_out) |-> $past(sclk_fall));

    // R8: a settled idle state neither drives the pin nor writes.
    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) && ($past(st) == ST_IDLE) |-> !dio_oe && !wr_en);

endmodule

bind serreg_port serreg_port_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .dio_out   (dio_out),
    .dio_oe    (dio_oe),
    .wr_en     (wr_en),
    .rd_flag   (rd_flag),
    .sclk_fall (sclk_fall),
    .st        (st),
    .mode      (mode)
);

// File: tb/tb_serreg_port.sv
module tb_serreg_port;

    localparam int H = 8;   // serial half period in core clocks

    logic clk = 1'b0;
    logic rst_n;
    logic cs_n;
    logic sclk;
    logic dio_in;
    logic rx_in;
    logic dio_out;
    logic dio_oe;

    int   nchk  = 0;
    int   nfail = 0;
    logic [7:0] model [128];

    always #2 clk = ~clk;

    serreg_port dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n    (cs_n),
        .sclk    (sclk),
        .dio_in  (dio_in),
        .rx_in   (rx_in),
        .dio_out (dio_out),
        .dio_oe  (dio_oe)
    );

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        nchk++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Expected serial order of the 16 bits for one transaction.
    function automatic logic [15:0] frame(input bit lsb, input bit rd,
                                          input logic [6:0] a, input logic [7:0] d);
        logic [15:0] f;
        f[0] = rd;
        for (int i = 0; i < 7; i++) f[1 + i] = lsb ? a[i] : a[6 - i];
        for (int i = 0; i < 8; i++) f[8 + i] = lsb ? d[i] : d[7 - i];
        return f;
    endfunction

    task automatic xfer(input bit lsb, input bit rd, input logic [6:0] a,
                        input logic [7:0] wd, input int nbits,
                        output logic [7:0] rdat, output bit oe_bad);
        logic [15:0] f;
        f      = frame(lsb, rd, a, wd);
        rdat   = '0;
        oe_bad = 1'b0;
        sclk   = lsb;
        waitc(H);
        cs_n = 1'b0;
        waitc(H);
        for (int b = 0; b < nbits; b++) begin
            sclk = 1'b0;
            if (lsb) begin
                dio_in = f[b];
                rx_in  = 1'($urandom);
            end else begin
                rx_in  = f[b];
                dio_in = 1'($urandom);
            end
            waitc(H);
            if (b >= 8) begin
                if (rd) begin
                    rdat[lsb ? b - 8 : 15 - b] = dio_out;
                    if (!dio_oe) oe_bad = 1'b1;
                end else if (dio_oe) begin
                    oe_bad = 1'b1;
                end
            end
            sclk = 1'b1;
            waitc(H);
        end
        if (!lsb) begin
            sclk = 1'b0;
            waitc(H);
        end
        cs_n = 1'b1;
        waitc(2 * H);
    endtask

    task automatic do_write(input bit lsb, input logic [6:0] a, input logic [7:0] d);
        logic [7:0] r;
        bit         bad;
        xfer(lsb, 1'b0, a, d, 16, r, bad);
        model[a] = d;
        chk("R7 oe low in write", 32'(bad), 32'd0);
        chk("R6 oe after cs high", 32'(dio_oe), 32'd0);
    endtask

    task automatic do_read(input bit lsb, input logic [6:0] a);
        logic [7:0] r;
        bit         bad;
        xfer(lsb, 1'b1, a, 8'($urandom), 16, r, bad);
        if (lsb) chk("R1 R2 R4 read lsb mode", 32'(r), 32'(model[a]));
        else     chk("R1 R3 R4 R9 read spi mode", 32'(r), 32'(model[a]));
        chk("R7 oe high in read", 32'(bad), 32'd0);
        chk("R6 oe after cs high", 32'(dio_oe), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: got hang expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        logic [7:0] r;
        bit         bad;
        void'($urandom(32'h1D2C3B4A));
        for (int i = 0; i < 128; i++) model[i] = 8'h00;
        rst_n  = 1'b0;
        cs_n   = 1'b1;
        sclk   = 1'b0;
        dio_in = 1'b0;
        rx_in  = 1'b0;
        waitc(5);
        rst_n = 1'b1;
        waitc(4);

        // R8: reset state.
        chk("R8 oe after reset", 32'(dio_oe), 32'd0);
        chk("R8 out after reset", 32'(dio_out), 32'd0);
        do_read(1'b1, 7'h00);
        do_read(1'b0, 7'h7F);
        do_read(1'b1, 7'h40);

        // R1 R2 R3: write in one mode, read in the other.
        do_write(1'b1, 7'h2A, 8'hC3);
        do_read (1'b0, 7'h2A);
        do_write(1'b0, 7'h7F, 8'h81);
        do_read (1'b1, 7'h7F);
        do_write(1'b0, 7'h01, 8'h01);
        do_read (1'b1, 7'h01);
        do_write(1'b1, 7'h40, 8'h80);
        do_read (1'b0, 7'h40);

        // R5: aborted writes leave registers unchanged.
        xfer(1'b1, 1'b0, 7'h2A, 8'h55, 12, r, bad);
        do_read(1'b0, 7'h2A);
        xfer(1'b0, 1'b0, 7'h7F, 8'h00, 15, r, bad);
        do_read(1'b1, 7'h7F);
        xfer(1'b1, 1'b0, 7'h01, 8'hFF, 4, r, bad);
        do_read(1'b1, 7'h01);
        chk("R5 abort keeps 0x2A", 32'(model[7'h2A]), 32'h0000_00C3);

        // Mixed random traffic.
        for (int k = 0; k < 70; k++) begin
            bit         m;
            bit         rd;
            logic [6:0] a;
            m  = 1'($urandom);
            rd = 1'($urandom);
            a  = 7'($urandom);
            if (rd) do_read(m, a);
            else    do_write(m, a, 8'($urandom));
        end

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule